// File: doc/BRIEF.md
# AC'97 Codec Register Access Engine

This block carries register traffic between a host and an AC'97 codec. The host fills holding registers for the command slot (slot 1) and the data slot (slot 2). At the next frame boundary the block hands the committed words and their tag bits to the link serialiser. It also takes the status slots the serialiser delivers from the codec and holds them for the host. The serialiser marks each frame with a one-cycle frame-start strobe. Words cross between the two sides as parallel 20-bit slot values.

A write is done in two steps. The data word goes into the slot-2 holding register first. Loading slot 1 then commits the pair to the next frame. A read sends only slot 1, with the read flag set. The codec echoes the register address in its returned slot 1, and the block compares that echo with the last address the host requested. Returned data is passed to the host only when the two agree. A control register enables the engine and each slot direction, and selects one of four codecs. A separate register drives the codec's active-low reset line.

Top module: `ac97_cmd_engine`

## Requirements
- R1: After reset: codec_rst_n is 0, tx_tag and both tx slot words are 0, and the status word (host address 5) and the control word (host address 0) read 0.
- R2: A host write to address 1 loads the slot-1 word and sets the slot-1 busy flag (status bit 0). The word carries the register address in bits 18:12 and the read flag in bit 19 (1 = read). On the first frame_start after that, with the engine enabled (control bit 0) and slot-1 transmit enabled (control bit 1), tx_slot1 presents the word and tx_tag bit 0 is 1 until the next frame_start, and the busy flag clears.
- R3: A host write to address 2 loads the slot-2 word and sets the slot-2 busy flag (status bit 1). The word carries the data in bits 19:4. Slot 2 is sent (tx_slot2 = word, tx_tag bit 1 = 1) only in the frame that also sends slot 1, and only with slot-2 transmit enabled (control bit 2). A slot-2 word loaded on its own stays pending, with its busy flag set.
- R4: In a frame that has no word to send, the slot word is 0 and its tag bit is 0. tx_tag and the tx slot words change only on frame_start.
- R5: With the slot-1 transmit enable cleared, frame_start sends nothing, and a pending slot-1 word keeps its busy flag until the enable is set again.
- R6: On rx_strobe, each slot whose rx_tag bit is set is captured if the engine is enabled and that slot's receive enable is set (control bit 3 for slot 1, bit 4 for slot 2). The capture sets its valid flag (status bit 2 or bit 3). A host read of address 3 returns the raw slot-1 word and clears valid 1. A host read of address 4 clears valid 2. A slot whose receive enable is cleared is not captured.
- R7: When slot 1 is captured, its echoed address (bits 18:12) is compared with the address in the last slot-1 word the host wrote, and the result is shown in status bit 4. A read of address 4 returns the slot-2 data field (bits 19:4) when they match, and 16'hFFFF when they do not.
- R8: The codec_sel output follows control bits 6:5 and selects codec 0 to 3.
- R9: Writing 0 to host address 6 drives codec_rst_n low. Writing 1 in bit 0 of address 6 releases it high. Reading address 6 returns the current state of the release bit.
- R10: While the engine enable (control bit 0) is 0, all busy and valid flags and the echo-match flag are held clear, from the cycle after the enable is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe (read side effects) |
| host_addr | input | 3 | Host register address |
| host_wdata | input | 20 | Host write data |
| host_rdata | output | 20 | Host read data for host_addr |
| frame_start | input | 1 | One-cycle strobe at each outgoing frame boundary |
| tx_tag | output | 2 | Tag bits for slots 1 (bit 0) and 2 (bit 1) |
| tx_slot1 | output | 20 | Outgoing slot-1 word |
| tx_slot2 | output | 20 | Outgoing slot-2 word |
| rx_strobe | input | 1 | A received frame's slots are present |
| rx_tag | input | 2 | Received tag bits for slots 1 and 2 |
| rx_slot1 | input | 20 | Received slot-1 word |
| rx_slot2 | input | 20 | Received slot-2 word |
| codec_sel | output | 2 | Selected codec number |
| codec_rst_n | output | 1 | Active-low codec reset |

## Verification
The bound checker checks on every cycle that a sending frame clears slot-1 busy and raises its tag, and that slot 2 never goes out without slot 1. It also checks that an idle frame carries zero words and that tags move only on frame_start, that a disabled slot keeps its pending word, that an enabled capture sets valid, and that disabling the engine empties every flag. The bench scenarios alone can show the values that come back: the slot-word encodings, the echo comparison that chooses between the data and all-ones, read-to-clear, codec select and the reset line.

// File: rtl/ac97_cmd_pkg.sv
package ac97_cmd_pkg;

    localparam int SLOT_W   = 20;
    localparam int REG_AW   = 7;
    localparam int REG_DW   = 16;
    localparam int SEL_W    = 2;
    localparam int HOST_AW  = 3;
    localparam int ADDR_LSB = 12;
    localparam int DATA_LSB = 4;
    localparam int NSLOT    = 2;

    typedef enum logic [HOST_AW-1:0] {
        HR_CTRL = 3'd0,
        HR_TX1  = 3'd1,
        HR_TX2  = 3'd2,
        HR_RX1  = 3'd3,
        HR_RX2  = 3'd4,
        HR_STAT = 3'd5,
        HR_RST  = 3'd6,
        HR_NONE = 3'd7
    } host_reg_e;

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic             rx2_en;
        logic             rx1_en;
        logic             tx2_en;
        logic             tx1_en;
        logic             glob_en;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    typedef struct packed {
        logic       match;
        logic [1:0] valid;
        logic [1:0] busy;
    } status_t;

    function automatic logic [REG_DW-1:0] rx_result(
        input logic               hit,
        input logic [SLOT_W-1:0]  word
    );
        return hit ? word[DATA_LSB +: REG_DW] : {REG_DW{1'b1}};
    endfunction

endpackage

// File: rtl/ac97_ctrl_regs.sv
module ac97_ctrl_regs
    import ac97_cmd_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_ctrl,
    input  logic                wr_reset,
    input  logic [CTRL_W-1:0]   wdata,
    output ctrl_t               ctrl,
    output logic                codec_rst_n
);

    ctrl_t ctrl_q;
    logic  rel_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            rel_q  <= 1'b0;
        end else begin
            if (wr_ctrl)
                ctrl_q <= ctrl_t'(wdata);
            if (wr_reset)
                rel_q <= wdata[0];
        end
    end

    assign ctrl        = ctrl_q;
    assign codec_rst_n = rel_q;

endmodule

// File: rtl/ac97_tx_path.sv
module ac97_tx_path #(
    parameter int SLOT_W = 20,
    parameter int NSLOT  = 2
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          flush,
    input  logic                          frame_start,
    input  logic [NSLOT-1:0]              en,
    input  logic [NSLOT-1:0]              wr,
    input  logic [SLOT_W-1:0]             wdata,
    output logic [NSLOT-1:0]              busy,
    output logic [NSLOT-1:0]              tag,
    output logic [NSLOT-1:0][SLOT_W-1:0]  slot_out
);

    logic [NSLOT-1:0] send;

    // slot 0 leads; every later slot rides only with the frame that sends slot 0
    always_comb begin
        send[0] = frame_start & busy[0] & en[0];
        for (int k = 1; k < NSLOT; k++)
            send[k] = send[0] & busy[k] & en[k];
    end

    for (genvar i = 0; i < NSLOT; i++) begin : g_slot
        logic [SLOT_W-1:0] hold_q;
        logic [SLOT_W-1:0] out_q;
        logic              busy_q;
        logic              tag_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                hold_q <= '0;
                out_q  <= '0;
                busy_q <= 1'b0;
                tag_q  <= 1'b0;
            end else begin
                if (wr[i])
                    hold_q <= wdata;
                if (flush)
                    busy_q <= 1'b0;
                else if (wr[i])
                    busy_q <= 1'b1;
                else if (send[i])
                    busy_q <= 1'b0;
                if (frame_start) begin
                    tag_q <= send[i];
                    out_q <= send[i] ? hold_q : '0;
                end
            end
        end

        assign busy[i]     = busy_q;
        assign tag[i]      = tag_q;
        assign slot_out[i] = out_q;
    end

endmodule

// File: rtl/ac97_rx_path.sv
module ac97_rx_path #(
    parameter int SLOT_W   = 20,
    parameter int NSLOT    = 2,
    parameter int REG_AW   = 7,
    parameter int ADDR_LSB = 12
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          flush,
    input  logic                          strobe,
    input  logic [NSLOT-1:0]              en,
    input  logic [NSLOT-1:0]              tag,
    input  logic [NSLOT-1:0][SLOT_W-1:0]  din,
    input  logic [NSLOT-1:0]              rd_clr,
    input  logic                          req_wr,
    input  logic [REG_AW-1:0]             req_addr,
    output logic [NSLOT-1:0]              valid,
    output logic [NSLOT-1:0][SLOT_W-1:0]  word,
    output logic                          match
);

    logic [NSLOT-1:0]  cap;
    logic [REG_AW-1:0] req_q;
    logic              match_q;

    assign cap = {NSLOT{strobe}} & tag & en;

    for (genvar i = 0; i < NSLOT; i++) begin : g_slot
        logic [SLOT_W-1:0] word_q;
        logic              valid_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                word_q  <= '0;
                valid_q <= 1'b0;
            end else begin
                if (cap[i])
                    word_q <= din[i];
                if (flush)
                    valid_q <= 1'b0;
                else if (cap[i])
                    valid_q <= 1'b1;
                else if (rd_clr[i])
                    valid_q <= 1'b0;
            end
        end

        assign word[i]  = word_q;
        assign valid[i] = valid_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q   <= '0;
            match_q <= 1'b0;
        end else begin
            if (req_wr)
                req_q <= req_addr;
            if (flush)
                match_q <= 1'b0;
            else if (cap[0])
                match_q <= (din[0][ADDR_LSB +: REG_AW] == req_q);
        end
    end

    assign match = match_q;

endmodule

// File: rtl/ac97_cmd_engine.sv
module ac97_cmd_engine
    import ac97_cmd_pkg::*;
#(
    parameter int W_SLOT = SLOT_W,
    parameter int W_HADR = HOST_AW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [W_HADR-1:0] host_addr,
    input  logic [W_SLOT-1:0] host_wdata,
    output logic [W_SLOT-1:0] host_rdata,
    input  logic              frame_start,
    output logic [1:0]        tx_tag,
    output logic [W_SLOT-1:0] tx_slot1,
    output logic [W_SLOT-1:0] tx_slot2,
    input  logic              rx_strobe,
    input  logic [1:0]        rx_tag,
    input  logic [W_SLOT-1:0] rx_slot1,
    input  logic [W_SLOT-1:0] rx_slot2,
    output logic [SEL_W-1:0]  codec_sel,
    output logic              codec_rst_n
);

    localparam int STAT_W = $bits(status_t);

    host_reg_e                        hreg;
    ctrl_t                            ctrl;
    logic                             flush;
    logic [NSLOT-1:0]                 tx_wr;
    logic [NSLOT-1:0]                 tx_en;
    logic [NSLOT-1:0]                 rx_en;
    logic [NSLOT-1:0]                 rd_clr;
    logic [NSLOT-1:0]                 tx_busy;
    logic [NSLOT-1:0]                 rx_valid;
    logic [NSLOT-1:0][W_SLOT-1:0]     tx_words;
    logic [NSLOT-1:0][W_SLOT-1:0]     rx_words;
    logic                             echo_match;
    status_t                          stat;

    always_comb begin
        case (host_addr)
            3'd0:    hreg = HR_CTRL;
            3'd1:    hreg = HR_TX1;
            3'd2:    hreg = HR_TX2;
            3'd3:    hreg = HR_RX1;
            3'd4:    hreg = HR_RX2;
            3'd5:    hreg = HR_STAT;
            3'd6:    hreg = HR_RST;
            default: hreg = HR_NONE;
        endcase
    end

    assign flush  = ~ctrl.glob_en;
    assign tx_wr  = {host_wr & (hreg == HR_TX2), host_wr & (hreg == HR_TX1)};
    assign tx_en  = {ctrl.tx2_en, ctrl.tx1_en} & {NSLOT{ctrl.glob_en}};
    assign rx_en  = {ctrl.rx2_en, ctrl.rx1_en} & {NSLOT{ctrl.glob_en}};
    assign rd_clr = {host_rd & (hreg == HR_RX2), host_rd & (hreg == HR_RX1)};

    ac97_ctrl_regs u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .wr_ctrl     (host_wr & (hreg == HR_CTRL)),
        .wr_reset    (host_wr & (hreg == HR_RST)),
        .wdata       (host_wdata[CTRL_W-1:0]),
        .ctrl        (ctrl),
        .codec_rst_n (codec_rst_n)
    );

    ac97_tx_path #(
        .SLOT_W (W_SLOT),
        .NSLOT  (NSLOT)
    ) u_tx (
        .clk         (clk),
        .rst         (rst),
        .flush       (flush),
        .frame_start (frame_start),
        .en          (tx_en),
        .wr          (tx_wr),
        .wdata       (host_wdata),
        .busy        (tx_busy),
        .tag         (tx_tag),
        .slot_out    (tx_words)
    );

    ac97_rx_path #(
        .SLOT_W   (W_SLOT),
        .NSLOT    (NSLOT),
        .REG_AW   (REG_AW),
        .ADDR_LSB (ADDR_LSB)
    ) u_rx (
        .clk      (clk),
        .rst      (rst),
        .flush    (flush),
        .strobe   (rx_strobe),
        .en       (rx_en),
        .tag      (rx_tag),
        .din      ({rx_slot2, rx_slot1}),
        .rd_clr   (rd_clr),
        .req_wr   (tx_wr[0]),
        .req_addr (host_wdata[ADDR_LSB +: REG_AW]),
        .valid    (rx_valid),
        .word     (rx_words),
        .match    (echo_match)
    );

    assign tx_slot1  = tx_words[0];
    assign tx_slot2  = tx_words[1];
    assign codec_sel = ctrl.sel;

    always_comb begin
        stat.match = echo_match;
        stat.valid = rx_valid;
        stat.busy  = tx_busy;
    end

    always_comb begin
        host_rdata = '0;
        case (hreg)
            HR_CTRL: host_rdata = W_SLOT'(ctrl);
            HR_RX1:  host_rdata = rx_words[0];
            HR_RX2:  host_rdata = W_SLOT'(rx_result(echo_match, rx_words[1]));
            HR_STAT: host_rdata = W_SLOT'(stat);
            HR_RST:  host_rdata = W_SLOT'(codec_rst_n);
            default: host_rdata = '0;
        endcase
    end

    logic unused_stat_w;
    assign unused_stat_w = (STAT_W == 0);

endmodule

// File: rtl/ac97_cmd_engine_chk.sv
module ac97_cmd_engine_chk (
    input logic        clk,
    input logic        rst,
    input logic        frame_start,
    input logic [1:0]  tx_tag,
    input logic [19:0] tx_slot1,
    input logic [1:0]  tx_busy,
    input logic        rx_strobe,
    input logic [1:0]  rx_tag,
    input logic [1:0]  rx_valid,
    input logic        glob_en,
    input logic        tx1_en,
    input logic        rx1_en,
    input logic        host_wr,
    input logic [2:0]  host_addr
);

    logic slot1_go;
    assign slot1_go = glob_en && tx1_en && tx_busy[0];

    AST_SEND_CLEARS_BUSY: assert property (@(posedge clk) disable iff (rst)
        frame_start && slot1_go && !(host_wr && host_addr == 3'd1)
        |=> !tx_busy[0] && tx_tag[0]); // R2

    AST_SLOT2_NEEDS_SLOT1: assert property (@(posedge clk) disable iff (rst)
        frame_start && !slot1_go |=> !tx_tag[1]); // R3

    AST_IDLE_SLOT_ZERO: assert property (@(posedge clk) disable iff (rst)
        frame_start && !slot1_go |=> !tx_tag[0] && tx_slot1 == 20'd0); // R4

    AST_TAG_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !frame_start |=> $stable(tx_tag) && $stable(tx_slot1)); // R4

    AST_TX_GATED: assert property (@(posedge clk) disable iff (rst)
        frame_start && glob_en && !tx1_en && tx_busy[0] |=> tx_busy[0]); // R5

    AST_CAPTURE_SETS_VALID: assert property (@(posedge clk) disable iff (rst)
        rx_strobe && rx_tag[0] && rx1_en && glob_en |=> rx_valid[0]); // R6

    AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (rst)
        !glob_en |=> tx_busy == 2'b00 && rx_valid == 2'b00); // R10

endmodule

bind ac97_cmd_engine ac97_cmd_engine_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .frame_start (frame_start),
    .tx_tag      (tx_tag),
    .tx_slot1    (tx_slot1),
    .tx_busy     (tx_busy),
    .rx_strobe   (rx_strobe),
    .rx_tag      (rx_tag),
    .rx_valid    (rx_valid),
    .glob_en     (ctrl.glob_en),
    .tx1_en      (ctrl.tx1_en),
    .rx1_en      (ctrl.rx1_en),
    .host_wr     (host_wr),
    .host_addr   (host_addr)
);

// File: tb/ac97_cmd_engine_test.sv
`timescale 1ns/1ps
module ac97_cmd_engine_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_wr = 1'b0;
    logic        host_rd = 1'b0;
    logic [2:0]  host_addr = '0;
    logic [19:0] host_wdata = '0;
    logic [19:0] host_rdata;
    logic        frame_start = 1'b0;
    logic [1:0]  tx_tag;
    logic [19:0] tx_slot1;
    logic [19:0] tx_slot2;
    logic        rx_strobe = 1'b0;
    logic [1:0]  rx_tag = '0;
    logic [19:0] rx_slot1 = '0;
    logic [19:0] rx_slot2 = '0;
    logic [1:0]  codec_sel;
    logic        codec_rst_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    ac97_cmd_engine uut (
        .clk         (clk),
        .rst         (rst),
        .host_wr     (host_wr),
        .host_rd     (host_rd),
        .host_addr   (host_addr),
        .host_wdata  (host_wdata),
        .host_rdata  (host_rdata),
        .frame_start (frame_start),
        .tx_tag      (tx_tag),
        .tx_slot1    (tx_slot1),
        .tx_slot2    (tx_slot2),
        .rx_strobe   (rx_strobe),
        .rx_tag      (rx_tag),
        .rx_slot1    (rx_slot1),
        .rx_slot2    (rx_slot2),
        .codec_sel   (codec_sel),
        .codec_rst_n (codec_rst_n)
    );

    // {echo mismatch, register address, read flag, data}
    localparam logic [24:0] VEC [4] = '{
        {1'b0, 7'h26, 1'b1, 16'h0000},
        {1'b1, 7'h02, 1'b1, 16'h1234},
        {1'b0, 7'h7C, 1'b0, 16'h801E},
        {1'b1, 7'h18, 1'b0, 16'hA5A5}
    };

    localparam logic [19:0] CTRL_ALL = 20'h5F; // all enables, codec 2

    task automatic check(input string what, input logic [19:0] act, input logic [19:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic hwrite(input logic [2:0] a, input logic [19:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic hread(input logic [2:0] a, output logic [19:0] d);
        @(negedge clk);
        host_addr = a; host_rd = 1'b1;
        #1 d = host_rdata;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic frame();
        @(negedge clk);
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
    endtask

    task automatic rxframe(input logic [1:0] t, input logic [19:0] s1, input logic [19:0] s2);
        @(negedge clk);
        rx_strobe = 1'b1; rx_tag = t; rx_slot1 = s1; rx_slot2 = s2;
        @(negedge clk);
        rx_strobe = 1'b0; rx_tag = '0;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        logic [19:0] rd;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check("R1 codec_rst_n", {19'd0, codec_rst_n}, 20'd0);
        check("R1 tx_tag", {18'd0, tx_tag}, 20'd0);
        check("R1 tx_slot1", tx_slot1, 20'd0);
        hread(3'd5, rd); check("R1 status", rd, 20'd0);
        hread(3'd0, rd); check("R1 ctrl", rd, 20'd0);

        // R9 codec reset line
        hwrite(3'd6, 20'd1); check("R9 release", {19'd0, codec_rst_n}, 20'd1);
        hwrite(3'd6, 20'd0); check("R9 assert", {19'd0, codec_rst_n}, 20'd0);
        hwrite(3'd6, 20'd1); hread(3'd6, rd); check("R9 readback", rd, 20'd1);

        // R8 codec select
        hwrite(3'd0, CTRL_ALL);
        check("R8 codec_sel 2", {18'd0, codec_sel}, 20'd2);
        hread(3'd0, rd); check("R8 ctrl readback", rd, CTRL_ALL);

        // table walk: R2 R3 R4 R6 R7
        for (int i = 0; i < 4; i++) begin
            logic        mis;
            logic [6:0]  ad;
            logic        rf;
            logic [15:0] dt;
            logic [6:0]  echo;
            {mis, ad, rf, dt} = VEC[i];
            echo = mis ? (ad ^ 7'h01) : ad;
            hwrite(3'd2, {dt, 4'h0});
            hwrite(3'd1, {rf, ad, 12'h000});
            hread(3'd5, rd); check("R2 R3 busy set", rd & 20'h3, 20'h3);
            frame();
            check("R2 slot1 word", tx_slot1, {rf, ad, 12'h000});
            check("R3 slot2 word", tx_slot2, {dt, 4'h0});
            check("R2 R3 tags", {18'd0, tx_tag}, 20'h3);
            hread(3'd5, rd); check("R2 busy clear", rd & 20'h3, 20'h0);
            frame();
            check("R4 idle tags", {18'd0, tx_tag}, 20'h0);
            check("R4 idle slot1", tx_slot1, 20'h0);
            check("R4 idle slot2", tx_slot2, 20'h0);
            rxframe(2'b11, {1'b0, echo, 12'h000}, {~dt, 4'h0});
            hread(3'd5, rd); check("R6 R7 valid and match", rd, {15'd0, ~mis, 4'b1100});
            hread(3'd3, rd); check("R6 rx1 word", rd, {1'b0, echo, 12'h000});
            hread(3'd4, rd); check("R7 rx2 result", rd, {4'h0, mis ? 16'hFFFF : ~dt});
            hread(3'd5, rd); check("R6 valid cleared", rd & 20'hC, 20'h0);
        end

        // R3 slot 2 alone stays pending
        hwrite(3'd2, 20'hABCD0);
        frame();
        check("R3 slot2 alone tag", {18'd0, tx_tag}, 20'h0);
        hread(3'd5, rd); check("R3 slot2 still busy", rd & 20'h3, 20'h2);
        hwrite(3'd1, 20'h83000);
        frame();
        check("R3 pair sent tags", {18'd0, tx_tag}, 20'h3);
        check("R3 pair slot2", tx_slot2, 20'hABCD0);

        // R5 transmit gating
        hwrite(3'd0, 20'h5D);
        hwrite(3'd1, 20'h05000);
        frame();
        check("R5 gated tag", {18'd0, tx_tag}, 20'h0);
        hread(3'd5, rd); check("R5 busy kept", rd & 20'h3, 20'h1);
        hwrite(3'd0, CTRL_ALL);
        frame();
        check("R5 sent after enable", tx_slot1, 20'h05000);
        check("R5 tag after enable", {18'd0, tx_tag}, 20'h1);

        // R6 receive gating
        hwrite(3'd0, 20'h57);
        rxframe(2'b01, 20'h11110, 20'h0);
        hread(3'd5, rd); check("R6 rx1 disabled ignored", rd & 20'h4, 20'h0);

        // R8 codec 3
        hwrite(3'd0, 20'h7F);
        check("R8 codec_sel 3", {18'd0, codec_sel}, 20'd3);

        // R10 flush
        hwrite(3'd0, 20'h7D);
        hwrite(3'd1, 20'h06000);
        rxframe(2'b11, 20'h06000, 20'h22220);
        hread(3'd5, rd); check("R10 flags before flush", rd & 20'hF, 20'hD);
        hwrite(3'd0, 20'h0);
        @(negedge clk);
        hread(3'd5, rd); check("R10 flags flushed", rd, 20'h0);
        hwrite(3'd1, 20'h07000);
        hread(3'd5, rd); check("R10 no busy while disabled", rd, 20'h0);
        hwrite(3'd0, CTRL_ALL);
        frame();
        check("R10 nothing pending after flush", {18'd0, tx_tag}, 20'h0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule